// File: doc/BRIEF.md
# ROM Overlay Bank-Switch Controller

This block sits on the bus of an 8-bit CPU with a 16-bit address. It lays 16 KB of RAM over the upper ROM region from 0xD000 to 0xFFFF. The window 0xD000–0xDFFF is shared by two 4 KB banks. The region 0xE000–0xFFFF has a single 8 KB bank. Sixteen switch addresses at 0xC080–0xC08F control the overlay. Any access to one of them, read or write, reprograms the read-enable, the write-enable and the active 4 KB bank. The data value of that access plays no part.

Each bus cycle is marked by a one-cycle strobe. The controller decodes the cycle combinationally against its current switch state. From that it drives a RAM chip select, a RAM physical address, a RAM write strobe and a ROM select, and it steers the read data back to the CPU. The switch state changes at the clock edge that ends a switch access.

Write permission has a safeguard. It is granted only after two qualifying switch reads in a row. A switch write clears the count without ever granting permission.

Top module: `rom_overlay_ctrl`

## Requirements
- R1: After reset the overlay is unmapped, with read and write permission off and the grant counter at zero. Every read of 0xD000–0xFFFF selects the ROM (rom_cs=1, ram_cs=0), and writes there produce no ram_we.
- R2: An access with addr[15:4]=0xC08 is a switch access whether it reads or writes, and its data is ignored. A switch read returns 0 on bus_rdata and selects neither RAM nor ROM.
- R3: Any switch access maps the overlay and latches addr[3] as the bank select: 1 means bank 1 and 0 means bank 2. Window addresses go to ram_addr = {bank_sel, addr[11:0]}, so bank 1 spans 0x1000–0x1FFF and bank 2 spans 0x0000–0x0FFF. Addresses 0xE000–0xFFFF go to ram_addr = 0x2000 + (addr - 0xE000).
- R4: Switch addr[1:0] selects the read source. Codes 00 and 11 read RAM, codes 01 and 10 read ROM, and addr[2] has no effect.
- R5: A switch read or write with code 00 or 10 clears the grant counter and turns write permission off.
- R6: A switch read with code 01 or 11 increments the grant counter, which saturates at 2. Write permission turns on once the counter reaches 2 and stays on under further such reads.
- R7: A switch write with code 01 or 11 clears the grant counter, sets only the read source and leaves write permission as it was.
- R8: A write strobe to 0xD000–0xFFFF asserts ram_cs and ram_we only while the overlay is mapped with write permission on, whatever the read source. Otherwise the write is dropped, and a write never selects the ROM.
- R9: On a read of 0xD000–0xFFFF, bus_rdata carries ram_rdata when RAM is selected and rom_rdata when ROM is selected.
- R10: State advances once per strobed access. Cycles with bus_valid low select nothing and change nothing, even with a switch address on the bus.
- R11: Accesses outside the switch range and outside 0xD000–0xFFFF select nothing, return 0 and leave the switch state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle strobe marking a bus access |
| bus_we | input | 1 | 1 for a CPU write, 0 for a read |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data returned to the CPU |
| ram_rdata | input | 8 | Data from the overlay RAM |
| rom_rdata | input | 8 | Data from the ROM |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 14 | RAM physical address |
| ram_wdata | output | 8 | RAM write data |
| rom_cs | output | 1 | ROM select |

## Verification
The bench uses the default parameters: a 16-bit bus, a 4 KB shared window, an 8 KB upper bank and a grant count of 2. With these values, every switch code, both bank values and both ends of each physical range are covered in a few dozen accesses. A small grant count lets short runs cover the full count path: switch reads back to back, switch writes placed between them that reset the count, saturation, and idle cycles with a switch address held on the bus.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   typedef enum logic [1:0] {
      MODE_RAM_RO = 2'b00,
      MODE_ROM_WC = 2'b01,
      MODE_ROM_RO = 2'b10,
      MODE_RAM_WC = 2'b11
   } ovl_mode_e;

   typedef enum logic [1:0] {
      RGN_NONE   = 2'b00,
      RGN_SWITCH = 2'b01,
      RGN_WINDOW = 2'b10,
      RGN_HIGH   = 2'b11
   } ovl_region_e;

   typedef struct packed {
      logic mapped;
      logic rd_en;
      logic wr_en;
      logic bank_hi;
   } ovl_state_t;

endpackage

// File: rtl/ovl_region_decode.sv
module ovl_region_decode
   import ovl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SW_BASE  = 32'hC080,
   parameter int unsigned SW_AW    = 4,
   parameter int unsigned BANK_BIT = 3,
   parameter int unsigned WIN_BASE = 32'hD000,
   parameter int unsigned WIN_AW   = 12,
   parameter int unsigned HI_BASE  = 32'hE000,
   parameter int unsigned HI_AW    = 13
) (
   input  logic [ADDR_W-1:0] addr,
   output ovl_region_e       region,
   output ovl_mode_e         mode,
   output logic              bank_bit
);

   localparam logic [ADDR_W-1:0] SW_TAG  = ADDR_W'(SW_BASE >> SW_AW);
   localparam logic [ADDR_W-1:0] WIN_TAG = ADDR_W'(WIN_BASE >> WIN_AW);
   localparam logic [ADDR_W-1:0] HI_TAG  = ADDR_W'(HI_BASE >> HI_AW);

   generate
      if (SW_AW < 3 || BANK_BIT >= SW_AW || BANK_BIT < 2) begin : g_bad_sw
         $error("switch range must hold the two mode bits and the bank bit");
      end
      if ((SW_BASE % (1 << SW_AW)) != 0) begin : g_bad_sw_align
         $error("switch base not aligned to its range");
      end
      if ((WIN_BASE % (1 << WIN_AW)) != 0 || (HI_BASE % (1 << HI_AW)) != 0) begin : g_bad_align
         $error("overlay regions must be aligned to their size");
      end
      if (HI_BASE + (1 << HI_AW) > (1 << ADDR_W)) begin : g_bad_top
         $error("upper bank exceeds address space");
      end
   endgenerate

   logic sw_hit, win_hit, hi_hit;

   always_comb begin
      sw_hit  = (addr >> SW_AW)  == SW_TAG;
      win_hit = (addr >> WIN_AW) == WIN_TAG;
      hi_hit  = (addr >> HI_AW)  == HI_TAG;
      if (sw_hit)       region = RGN_SWITCH;
      else if (win_hit) region = RGN_WINDOW;
      else if (hi_hit)  region = RGN_HIGH;
      else              region = RGN_NONE;
      mode     = ovl_mode_e'(addr[1:0]);
      bank_bit = addr[BANK_BIT];
   end

endmodule

// File: rtl/ovl_switch_fsm.sv
module ovl_switch_fsm
   import ovl_pkg::*;
#(
   parameter int unsigned WR_GRANT_CNT = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_access,
   input  logic       sw_write,
   input  ovl_mode_e  mode,
   input  logic       bank_bit,
   output ovl_state_t state
);

   localparam int unsigned CNT_W = $clog2(WR_GRANT_CNT + 1);

   generate
      if (WR_GRANT_CNT < 1) begin : g_bad_grant
         $error("grant count must be at least one");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, cnt_n, cnt_inc;
   ovl_state_t       st_n;

   always_comb begin
      cnt_inc = (cnt == CNT_W'(WR_GRANT_CNT)) ? cnt : cnt + 1'b1;
      st_n    = state;
      cnt_n   = cnt;
      if (sw_access) begin
         st_n.mapped  = 1'b1;
         st_n.bank_hi = bank_bit;
         st_n.rd_en   = (mode == MODE_RAM_RO) || (mode == MODE_RAM_WC);
         if (mode == MODE_RAM_RO || mode == MODE_ROM_RO) begin
            cnt_n      = '0;
            st_n.wr_en = 1'b0;
         end else if (sw_write) begin
            cnt_n = '0;
         end else begin
            cnt_n = cnt_inc;
            if (cnt_inc >= CNT_W'(WR_GRANT_CNT)) st_n.wr_en = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= '0;
         cnt   <= '0;
      end else begin
         state <= st_n;
         cnt   <= cnt_n;
      end
   end

   // R6: counter never passes the grant value
   a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WR_GRANT_CNT));

   // R6: permission appears only with a full count
   a_r6_grant_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state.wr_en) |-> cnt == CNT_W'(WR_GRANT_CNT));

   // R7: switch write clears count and never grants
   a_r7_write_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_access && sw_write) |=> (cnt == '0) && !$rose(state.wr_en));

   // R5: clearing codes drop permission
   a_r5_clear_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_access && !mode[0]) |=> !state.wr_en && cnt == '0);

   // R10: no strobe, no change
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_access |=> $stable(state) && $stable(cnt));

endmodule

// File: rtl/ovl_bus_route.sv
module ovl_bus_route
   import ovl_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WIN_AW = 12,
   parameter int unsigned HI_AW  = 13,
   parameter int unsigned RAM_AW = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  ovl_region_e       region,
   input  ovl_state_t        state,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              rom_cs
);

   localparam logic [RAM_AW-1:0] HI_OFFSET = RAM_AW'(2 << WIN_AW);

   generate
      if ((2 << WIN_AW) + (1 << HI_AW) > (1 << RAM_AW)) begin : g_bad_ram
         $error("RAM address too narrow for both banks and upper bank");
      end
   endgenerate

   logic overlay, rd_ram, wr_ram;

   always_comb begin
      overlay = valid && (region == RGN_WINDOW || region == RGN_HIGH);
      rd_ram  = overlay && !we && state.mapped && state.rd_en;
      wr_ram  = overlay &&  we && state.mapped && state.wr_en;
      ram_cs  = rd_ram || wr_ram;
      ram_we  = wr_ram;
      rom_cs  = overlay && !we && !rd_ram;
      if (region == RGN_HIGH)
         ram_addr = HI_OFFSET + RAM_AW'(addr[HI_AW-1:0]);
      else
         ram_addr = RAM_AW'({state.bank_hi, addr[WIN_AW-1:0]});
      if (rd_ram)      bus_rdata = ram_rdata;
      else if (rom_cs) bus_rdata = rom_rdata;
      else             bus_rdata = '0;
   end

   // R8: RAM and ROM never selected together
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_cs && rom_cs));

   // R8: write strobe only with write permission
   a_r8_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> state.wr_en && ram_cs && !rom_cs);

   // R2: switch reads return zero
   a_r2_switch_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !we && region == RGN_SWITCH) |-> bus_rdata == '0 && !ram_cs && !rom_cs);

endmodule

// File: rtl/rom_overlay_ctrl.sv
module rom_overlay_ctrl
   import ovl_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned SW_BASE      = 32'hC080,
   parameter int unsigned WIN_BASE     = 32'hD000,
   parameter int unsigned WIN_AW       = 12,
   parameter int unsigned HI_BASE      = 32'hE000,
   parameter int unsigned HI_AW        = 13,
   parameter int unsigned WR_GRANT_CNT = 2,
   localparam int unsigned RAM_AW = $clog2((2 << WIN_AW) + (1 << HI_AW))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] rom_rdata,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              rom_cs
);

   ovl_region_e region;
   ovl_mode_e   mode;
   logic        bank_bit;
   ovl_state_t  state;

   ovl_region_decode #(
      .ADDR_W(ADDR_W), .SW_BASE(SW_BASE), .SW_AW(4), .BANK_BIT(3),
      .WIN_BASE(WIN_BASE), .WIN_AW(WIN_AW), .HI_BASE(HI_BASE), .HI_AW(HI_AW)
   ) u_dec (
      .addr(bus_addr), .region(region), .mode(mode), .bank_bit(bank_bit)
   );

   ovl_switch_fsm #(.WR_GRANT_CNT(WR_GRANT_CNT)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .sw_access(bus_valid && region == RGN_SWITCH),
      .sw_write(bus_we), .mode(mode), .bank_bit(bank_bit), .state(state)
   );

   ovl_bus_route #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .HI_AW(HI_AW), .RAM_AW(RAM_AW)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .we(bus_we), .addr(bus_addr),
      .region(region), .state(state), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
      .bus_rdata(bus_rdata), .ram_cs(ram_cs), .ram_we(ram_we),
      .ram_addr(ram_addr), .rom_cs(rom_cs)
   );

   assign ram_wdata = bus_wdata;

   // R1: first cycle out of reset is unmapped
   a_r1_reset_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !ram_cs);

endmodule

// File: tb/rom_overlay_ctrl_test.sv
module rom_overlay_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  ram_rdata = 8'hA5;
   logic [7:0]  rom_rdata = 8'h5A;
   logic        ram_cs, ram_we, rom_cs;
   logic [13:0] ram_addr;
   logic [7:0]  ram_wdata;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   rom_overlay_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .ram_cs(ram_cs),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rom_cs(rom_cs)
   );

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [7:0]  wd;
      logic        cs;
      logic        rom;
      logic        wen;
      logic [13:0] ra;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 35;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 16'hD000, 8'h00, 1'b0, 1'b1, 1'b0, 14'h0000, 4'd1},  // R1 read goes to ROM
      '{1'b1, 16'hD000, 8'h11, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd1},  // R1 write dropped
      '{1'b0, 16'hC080, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd2},  // R2 switch read, bank 2, RAM read
      '{1'b0, 16'hD123, 8'h00, 1'b1, 1'b0, 1'b0, 14'h0123, 4'd3},  // R3 bank 2 address
      '{1'b1, 16'hD123, 8'h22, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd8},  // R8 no write permission
      '{1'b0, 16'hC08B, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd6},  // R6 count 1, bank 1
      '{1'b0, 16'hD456, 8'h00, 1'b1, 1'b0, 1'b0, 14'h1456, 4'd3},  // R3 bank 1 address
      '{1'b1, 16'hD456, 8'h33, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd6},  // R6 one read not enough
      '{1'b0, 16'hC08B, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd6},  // R6 count 2, granted
      '{1'b1, 16'hD456, 8'h44, 1'b1, 1'b0, 1'b1, 14'h1456, 4'd6},  // R6 write lands
      '{1'b0, 16'hE010, 8'h00, 1'b1, 1'b0, 1'b0, 14'h2010, 4'd9},  // R9 RAM data, upper bank
      '{1'b0, 16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b0, 14'h3FFF, 4'd3},  // R3 top of upper bank
      '{1'b0, 16'hC081, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd6},  // R6 saturated, read ROM, bank 2
      '{1'b0, 16'hD001, 8'h00, 1'b0, 1'b1, 1'b0, 14'h0000, 4'd4},  // R4 code 01 reads ROM
      '{1'b1, 16'hD001, 8'h55, 1'b1, 1'b0, 1'b1, 14'h0001, 4'd8},  // R8 write with ROM read source
      '{1'b1, 16'hC08B, 8'hFF, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 switch write keeps permission
      '{1'b1, 16'hE000, 8'h66, 1'b1, 1'b0, 1'b1, 14'h2000, 4'd7},  // R7 permission still on
      '{1'b0, 16'hD800, 8'h00, 1'b1, 1'b0, 1'b0, 14'h1800, 4'd7},  // R7 read source now RAM, bank 1
      '{1'b0, 16'hC086, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd5},  // R5 code 10, bit2 set
      '{1'b1, 16'hE000, 8'h77, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd5},  // R5 permission cleared
      '{1'b0, 16'hE000, 8'h00, 1'b0, 1'b1, 1'b0, 14'h0000, 4'd4},  // R4 code 10 reads ROM
      '{1'b0, 16'hC083, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 count 1
      '{1'b1, 16'hC083, 8'hAA, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 write clears count
      '{1'b0, 16'hC083, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 count 1 again
      '{1'b1, 16'hD000, 8'h88, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd7},  // R7 no grant across a write
      '{1'b0, 16'hD000, 8'h00, 1'b1, 1'b0, 1'b0, 14'h0000, 4'd3},  // R3 bank 2 base
      '{1'b0, 16'hC08F, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd4},  // R4 bit2 set, count 2, bank 1
      '{1'b1, 16'hDFFF, 8'h99, 1'b1, 1'b0, 1'b1, 14'h1FFF, 4'd6},  // R6 granted, bank 1 top
      '{1'b0, 16'hC084, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd5},  // R5 code 00, bit2 set
      '{1'b1, 16'hDFFF, 8'h9A, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd5},  // R5 permission cleared
      '{1'b0, 16'hDFFF, 8'h00, 1'b1, 1'b0, 1'b0, 14'h0FFF, 4'd4},  // R4 code 00 reads RAM
      '{1'b0, 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd11}, // R11 unrelated read
      '{1'b1, 16'hC0FF, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd11}, // R11 near miss of switch range
      '{1'b0, 16'hDFFF, 8'h00, 1'b1, 1'b0, 1'b0, 14'h0FFF, 4'd11}, // R11 state unchanged
      '{1'b0, 16'hCFFF, 8'h00, 1'b0, 1'b0, 1'b0, 14'h0000, 4'd11}  // R11 just below window
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic v, input logic we, input logic [15:0] a, input logic [7:0] wd);
      @(negedge clk);
      bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = wd;
      #5;
   endtask

   task automatic expect_outs(input string tag, input logic cs, input logic rom,
                              input logic wen, input logic [13:0] ra, input logic we);
      logic [7:0] rd;
      rd = rom ? 8'h5A : ((cs && !we) ? 8'hA5 : 8'h00);
      check({tag, " ram_cs"}, 32'(ram_cs), 32'(cs));
      check({tag, " rom_cs"}, 32'(rom_cs), 32'(rom));
      check({tag, " ram_we"}, 32'(ram_we), 32'(wen));
      check({tag, " rdata"},  32'(bus_rdata), 32'(rd));
      if (cs) check({tag, " ram_addr"}, 32'(ram_addr), 32'(ra));
      if (cs && we) check({tag, " ram_wdata"}, 32'(ram_wdata), 32'(bus_wdata));
   endtask

   initial begin
      // R1: reset state seen while reset is held
      access(1'b1, 1'b0, 16'hD000, 8'h00);
      expect_outs("R1 in reset", 1'b0, 1'b1, 1'b0, 14'h0, 1'b0);
      @(negedge clk); rst_n = 1'b1; bus_valid = 1'b0;

      for (int i = 0; i < NV; i++) begin
         access(1'b1, VECS[i].we, VECS[i].addr, VECS[i].wd);
         expect_outs($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].cs, VECS[i].rom,
                     VECS[i].wen, VECS[i].ra, VECS[i].we);
      end

      // R10: one qualifying read, then idle cycles holding a switch address
      access(1'b1, 1'b0, 16'hC080, 8'h00);
      access(1'b1, 1'b0, 16'hC083, 8'h00);
      for (int k = 0; k < 5; k++) begin
         access(1'b0, 1'b0, 16'hC083, 8'h00);
         expect_outs("R10 idle", 1'b0, 1'b0, 1'b0, 14'h0, 1'b0);
      end
      access(1'b1, 1'b1, 16'hE123, 8'h3C);
      expect_outs("R10 no grant from idle", 1'b0, 1'b0, 1'b0, 14'h0, 1'b1);
      access(1'b1, 1'b0, 16'hC083, 8'h00);
      access(1'b1, 1'b1, 16'hE123, 8'h3C);
      expect_outs("R10 second strobe grants", 1'b1, 1'b0, 1'b1, 14'h2123, 1'b1);

      // R1: reset mid-run clears mapping, permission and count
      @(negedge clk); rst_n = 1'b0; bus_valid = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      access(1'b1, 1'b0, 16'hE123, 8'h00);
      expect_outs("R1 after reset read", 1'b0, 1'b1, 1'b0, 14'h0, 1'b0);
      access(1'b1, 1'b1, 16'hE123, 8'h00);
      expect_outs("R1 after reset write", 1'b0, 1'b0, 1'b0, 14'h0, 1'b1);
      access(1'b1, 1'b0, 16'hC08B, 8'h00);
      access(1'b1, 1'b1, 16'hD000, 8'h00);
      expect_outs("R1 count was zero", 1'b0, 1'b0, 1'b0, 14'h0, 1'b1);
      access(1'b1, 1'b0, 16'hD000, 8'h00);
      expect_outs("R1 bank 1 after reset", 1'b1, 1'b0, 1'b0, 14'h1000, 1'b0);

      access(1'b0, 1'b0, 16'h0000, 8'h00);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule